// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block sits beside the execute stage of a processor core and decides, from the current privilege level and two status trap controls, whether a privileged system instruction may proceed or must be turned into an illegal-instruction trap. It handles three instruction classes: wait-for-interrupt, the address-translation fence, and CSR access. The core presents one class per cycle on a one-hot vector. The block registers its verdict, so every output reflects the instruction presented on the previous clock edge.

A legal wait-for-interrupt raises a halt request, which holds until an interrupt becomes pending. A legal fence produces a single-cycle flush pulse for the translation cache. A legal CSR access produces read and, where applicable, write enables for the CSR file, which lies outside this block along with the translation cache. On a trap, the block reports cause code 2 and captures the whole 32-bit instruction word, rather than a fault address, into its trap value register.

Privilege encoding: 0 is user, 1 is supervisor, 3 is machine. The value 2 gets the same treatment as user. Class vector bits: bit 0 is wait-for-interrupt, bit 1 is fence, bit 2 is CSR access.

Top module: `priv_legality_check`

## Requirements
- R1: A wait-for-interrupt in machine mode is legal whatever the wait-timeout bit says. It gives one allow pulse and sets halt_req on the next cycle.
- R2: A wait-for-interrupt is illegal in user mode, and also in supervisor mode when the wait-timeout bit is 1. In supervisor mode with that bit at 0 it is legal.
- R3: A fence at a privilege below supervisor (encodings 0 and 2) is illegal.
- R4: A fence is illegal in supervisor mode when the trap-translation bit is 1. Any other fence at supervisor or machine level yields a one-cycle tlb_flush pulse and no allow.
- R5: A CSR access is illegal when csr_fault is 1. Otherwise it yields allow together with csr_rd_en.
- R6: A CSR access with csr_rmw=1 (set-bits or clear-bits form) and src_is_x0=1 gives csr_wr_en=0 while csr_rd_en stays 1. Every other legal CSR access gives csr_wr_en=1.
- R7: An illegal instruction asserts illegal with exc_cause=2. In the same cycle, trap_val shows the 32-bit instruction word, zero-extended.
- R8: Once set, halt_req stays high until irq_pending is seen, and it is low in the cycle after that. A legal wait-for-interrupt presented while irq_pending is 1 does not set it.
- R9: With an all-zero class vector, allow, tlb_flush, illegal, csr_rd_en and csr_wr_en are 0 on the next cycle and trap_val keeps its value.
- R10: allow, tlb_flush and illegal are never high together, and each is a one-cycle response to one presented instruction.
- R11: A class vector with more than one bit set is treated as illegal.
- R12: After reset every output is 0, including trap_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_class | input | 3 | One-hot class: bit0 WFI, bit1 fence, bit2 CSR |
| priv | input | 2 | Current privilege level |
| tw_bit | input | 1 | Wait-timeout trap control |
| tvm_bit | input | 1 | Trap-translation-management control |
| csr_fault | input | 1 | Access failure reported by the CSR file |
| csr_rmw | input | 1 | CSR access is a set-bits or clear-bits form |
| src_is_x0 | input | 1 | CSR source register is register zero |
| irq_pending | input | 1 | An interrupt is pending |
| insn_word | input | 32 | Instruction word being checked |
| allow | output | 1 | Instruction may complete |
| halt_req | output | 1 | Core halt request after a legal WFI |
| tlb_flush | output | 1 | Translation cache flush pulse |
| illegal | output | 1 | Illegal-instruction exception |
| exc_cause | output | CAUSE_W | Exception cause, 2 when illegal |
| trap_val | output | XLEN | Captured faulting instruction word |
| csr_rd_en | output | 1 | CSR read enable |
| csr_wr_en | output | 1 | CSR write enable |

## Verification
The bench sweeps every privilege encoding with both trap controls set and clear, so a design that ignored machine-mode immunity would trap a machine-level fence, and one that treated encoding 2 as supervisor would flush instead of trapping. It presents set-bits and clear-bits CSR forms with register zero as source; a design that ignored that case would raise a spurious write. It raises irq_pending while a halt is held and together with a new wait-for-interrupt, which catches a halt that lingers or latches too eagerly. Idle cycles between traps with a changing instruction word catch a trap value register that loads when it should hold.

// File: rtl/priv_legality_check.sv
module priv_legality_check #(
  parameter int XLEN = 32,
  parameter int CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] ILLEGAL_CAUSE = CAUSE_W'(2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         insn_class,
  input  logic [1:0]         priv,
  input  logic               tw_bit,
  input  logic               tvm_bit,
  input  logic               csr_fault,
  input  logic               csr_rmw,
  input  logic               src_is_x0,
  input  logic               irq_pending,
  input  logic [31:0]        insn_word,
  output logic               allow,
  output logic               halt_req,
  output logic               tlb_flush,
  output logic               illegal,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    trap_val,
  output logic               csr_rd_en,
  output logic               csr_wr_en
);
  localparam logic [1:0] LVL_S = 2'd1;
  localparam logic [1:0] LVL_M = 2'd3;

  logic in_m, in_s, multi, is_wfi, is_fence, is_csr;
  logic wfi_ok, fence_ok, trap_d, allow_d, flush_d, rd_d, wr_d;

  assign in_m     = (priv == LVL_M);
  assign in_s     = (priv == LVL_S);
  assign multi    = (insn_class & (insn_class - 3'd1)) != 3'd0;
  assign is_wfi   = insn_class[0] & ~multi;
  assign is_fence = insn_class[1] & ~multi;
  assign is_csr   = insn_class[2] & ~multi;

  assign wfi_ok   = in_m | (in_s & ~tw_bit);
  assign fence_ok = in_m | (in_s & ~tvm_bit);

  assign trap_d  = multi | (is_wfi & ~wfi_ok) | (is_fence & ~fence_ok) | (is_csr & csr_fault);
  assign allow_d = (is_wfi & wfi_ok) | (is_csr & ~csr_fault);
  assign flush_d = is_fence & fence_ok;
  assign rd_d    = is_csr & ~csr_fault;
  assign wr_d    = rd_d & ~(csr_rmw & src_is_x0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow     <= 1'b0;
      tlb_flush <= 1'b0;
      illegal   <= 1'b0;
      exc_cause <= '0;
      trap_val  <= '0;
      csr_rd_en <= 1'b0;
      csr_wr_en <= 1'b0;
      halt_req  <= 1'b0;
    end else begin
      allow     <= allow_d;
      tlb_flush <= flush_d;
      illegal   <= trap_d;
      exc_cause <= trap_d ? ILLEGAL_CAUSE : '0;
      csr_rd_en <= rd_d;
      csr_wr_en <= wr_d;
      if (trap_d)
        trap_val <= XLEN'(insn_word);
      if (irq_pending)
        halt_req <= 1'b0;
      else if (is_wfi & wfi_ok)
        halt_req <= 1'b1;
    end
  end
endmodule

// File: rtl/priv_legality_sva.sv
module priv_legality_sva #(
  parameter int XLEN = 32,
  parameter int CAUSE_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         insn_class,
  input logic [1:0]         priv,
  input logic               irq_pending,
  input logic [31:0]        insn_word,
  input logic               allow,
  input logic               halt_req,
  input logic               tlb_flush,
  input logic               illegal,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic [XLEN-1:0]    trap_val,
  input logic               csr_rd_en,
  input logic               csr_wr_en
);
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({allow, tlb_flush, illegal})); // R10
  AST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> exc_cause == CAUSE_W'(2)); // R7
  AST_TVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_class != 3'b000) ##1 illegal |-> trap_val == XLEN'($past(insn_word))); // R7
  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_class == 3'b000) |=> !allow && !tlb_flush && !illegal && !csr_rd_en && $stable(trap_val)); // R9
  AST_HALT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |=> !halt_req); // R8
  AST_USER_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_class == 3'b010 && priv == 2'd0) |=> illegal); // R3
  AST_WR_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en |-> csr_rd_en && allow); // R6
  AST_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(insn_class) > 1) |=> illegal); // R11
endmodule

bind priv_legality_check priv_legality_sva #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .insn_class(insn_class), .priv(priv),
  .irq_pending(irq_pending), .insn_word(insn_word), .allow(allow),
  .halt_req(halt_req), .tlb_flush(tlb_flush), .illegal(illegal),
  .exc_cause(exc_cause), .trap_val(trap_val), .csr_rd_en(csr_rd_en),
  .csr_wr_en(csr_wr_en)
);

// File: tb/test_priv_legality_check.sv
module test_priv_legality_check;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] insn_class = '0;
  logic [1:0] priv = '0;
  logic tw_bit = 0, tvm_bit = 0, csr_fault = 0, csr_rmw = 0, src_is_x0 = 0, irq_pending = 0;
  logic [31:0] insn_word = '0;
  logic allow, halt_req, tlb_flush, illegal, csr_rd_en, csr_wr_en;
  logic [4:0] exc_cause;
  logic [31:0] trap_val;

  always #2 clk = ~clk;

  priv_legality_check i_priv_legality_check (
    .clk(clk), .rst_n(rst_n), .insn_class(insn_class), .priv(priv),
    .tw_bit(tw_bit), .tvm_bit(tvm_bit), .csr_fault(csr_fault), .csr_rmw(csr_rmw),
    .src_is_x0(src_is_x0), .irq_pending(irq_pending), .insn_word(insn_word),
    .allow(allow), .halt_req(halt_req), .tlb_flush(tlb_flush), .illegal(illegal),
    .exc_cause(exc_cause), .trap_val(trap_val), .csr_rd_en(csr_rd_en), .csr_wr_en(csr_wr_en)
  );

  typedef struct packed {
    logic al, hl, fl, il, rd, wr;
    logic [4:0] cause;
    logic [31:0] tval;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0;
  logic m_halt = 0;
  logic [31:0] m_tval = '0;
  string tag = "";

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input string req, input logic [2:0] c, input logic [1:0] p,
                       input logic tw, input logic tvm, input logic flt, input logic rmw,
                       input logic x0, input logic irq, input logic [31:0] w);
    exp_t e;
    logic ok_w, ok_f, bad;
    @(negedge clk);
    insn_class = c; priv = p; tw_bit = tw; tvm_bit = tvm; csr_fault = flt;
    csr_rmw = rmw; src_is_x0 = x0; irq_pending = irq; insn_word = w;
    ok_w = (p == 2'd3) || (p == 2'd1 && !tw);
    ok_f = (p == 2'd3) || (p == 2'd1 && !tvm);
    e = '0;
    bad = 0;
    case (c)
      3'b000: ;
      3'b001: begin bad = !ok_w; e.al = ok_w; end
      3'b010: begin bad = !ok_f; e.fl = ok_f; end
      3'b100: begin bad = flt; e.al = !flt; e.rd = !flt; e.wr = !flt && !(rmw && x0); end
      default: bad = 1;
    endcase
    e.il = bad;
    e.cause = bad ? 5'd2 : 5'd0;
    if (bad) m_tval = w;
    e.tval = m_tval;
    if (irq) m_halt = 0;
    else if (c == 3'b001 && ok_w) m_halt = 1;
    e.hl = m_halt;
    tag = req;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (rst_n && q.size() > 0) begin
        e = q.pop_front();
        chk(tag, "allow", 32'(allow), 32'(e.al));
        chk(tag, "halt_req", 32'(halt_req), 32'(e.hl));
        chk(tag, "tlb_flush", 32'(tlb_flush), 32'(e.fl));
        chk(tag, "illegal", 32'(illegal), 32'(e.il));
        chk(tag, "csr_rd_en", 32'(csr_rd_en), 32'(e.rd));
        chk(tag, "csr_wr_en", 32'(csr_wr_en), 32'(e.wr));
        chk(tag, "exc_cause", 32'(exc_cause), 32'(e.cause));
        chk(tag, "trap_val", trap_val, e.tval);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "reset outputs", {allow, halt_req, tlb_flush, illegal, csr_rd_en, csr_wr_en, exc_cause}, 0);
    chk("R12", "reset trap_val", trap_val, 0);
    @(negedge clk); rst_n = 1;
    // R1 machine WFI with tw set, then clear via interrupt (R8)
    drive("R1", 3'b001, 2'd3, 1, 1, 0, 0, 0, 0, 32'h10500073);
    drive("R8", 3'b000, 2'd3, 0, 0, 0, 0, 0, 0, 32'h0);
    drive("R8", 3'b000, 2'd3, 0, 0, 0, 0, 0, 1, 32'h0);
    drive("R8", 3'b001, 2'd3, 0, 0, 0, 0, 0, 1, 32'h10500073);
    // R2 WFI rules
    drive("R2", 3'b001, 2'd0, 0, 0, 0, 0, 0, 0, 32'hAAAA0001);
    drive("R9", 3'b000, 2'd0, 0, 0, 0, 0, 0, 0, 32'h55555555);
    drive("R2", 3'b001, 2'd1, 1, 0, 0, 0, 0, 0, 32'hBBBB0002);
    drive("R2", 3'b001, 2'd1, 0, 1, 0, 0, 0, 0, 32'hCCCC0003);
    drive("R8", 3'b000, 2'd1, 0, 0, 0, 0, 0, 1, 32'h0);
    // R3 / R4 fences
    drive("R3", 3'b010, 2'd0, 0, 0, 0, 0, 0, 0, 32'h12000073);
    drive("R3", 3'b010, 2'd2, 0, 0, 0, 0, 0, 0, 32'h12100073);
    drive("R4", 3'b010, 2'd1, 0, 1, 0, 0, 0, 0, 32'h12200073);
    drive("R4", 3'b010, 2'd1, 1, 0, 0, 0, 0, 0, 32'h12300073);
    drive("R4", 3'b010, 2'd3, 1, 1, 0, 0, 0, 0, 32'h12400073);
    drive("R10", 3'b010, 2'd3, 0, 0, 0, 0, 0, 0, 32'h12500073);
    // R5 / R6 CSR
    drive("R5", 3'b100, 2'd0, 0, 0, 1, 0, 0, 0, 32'hDEADBEEF);
    drive("R5", 3'b100, 2'd0, 0, 0, 0, 0, 1, 0, 32'h34001073);
    drive("R6", 3'b100, 2'd1, 0, 0, 0, 1, 1, 0, 32'h34002073);
    drive("R6", 3'b100, 2'd3, 0, 0, 0, 1, 0, 0, 32'h3400A073);
    drive("R6", 3'b100, 2'd3, 0, 0, 1, 1, 1, 0, 32'hFEEDF00D);
    // R11 multi-hot, R9 idle hold
    drive("R11", 3'b101, 2'd3, 0, 0, 0, 0, 0, 0, 32'h0BADC0DE);
    drive("R11", 3'b011, 2'd3, 0, 0, 0, 0, 0, 0, 32'h0BADC0DF);
    drive("R9", 3'b000, 2'd3, 1, 1, 1, 1, 1, 0, 32'hFFFFFFFF);
    drive("R9", 3'b000, 2'd3, 0, 0, 0, 0, 0, 0, 32'h00000000);
    drive("R7", 3'b100, 2'd3, 0, 0, 1, 0, 0, 0, 32'h80000001);
    drive("R9", 3'b000, 2'd3, 0, 0, 0, 0, 0, 0, 32'h0);
    repeat (3) @(posedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule